// File: doc/BRIEF.md
# Periodic Activation Word Sampler

This block thins a data stream according to an activation word that is ultimately periodic. The word is a finite prefix followed by a cycle that repeats without end. Each present input consumes one bit of the word. When that bit is 1 the value is forwarded to the output. When the bit is 0 the value is dropped. The word can come from parameter defaults, or it can be loaded at run time through a small configuration port.

In composed mode a second word, the sub-word, is nested inside the base word. A base bit of 0 gives 0 and leaves the sub-word where it is. A base bit of 1 takes the next sub-word bit and passes it through unchanged. The resulting activation bit is also driven out on every cycle, so downstream logic can use it as the derived clock of the sampled stream.

Top module: `upw_sampler`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0. Both words return to their parameter defaults, and both positions return to the first bit of the prefix.
- R2: Bit i of a prefix vector (or of a period vector) is word position i, with bit 0 first. After the last prefix bit come the period bits. After the last period bit the position goes back to the first period bit.
- R3: When `in_valid` is 1 and the effective bit is 1, `out_valid` is 1 one clock later and `out_data` equals the sampled `in_data`.
- R4: When `in_valid` is 1 and the effective bit is 0, the value is dropped and `out_valid` is 0 one clock later.
- R5: When `in_valid` is 0, neither word position moves, and `out_valid` is 0 one clock later.
- R6: With `compose_en` = 1, the effective bit is base AND sub. The sub-word position advances only on present inputs whose base bit is 1.
- R7: `act_bit` equals `in_valid` AND the effective bit, in the same cycle and without a register.
- R8: A cycle with `cfg_we` = 1 loads the word chosen by `cfg_sel` (0 = base, 1 = sub) and restarts that word at position 0. A period length of 0 is taken as 1. Lengths above 16 are taken as 16.
- R9: With `compose_en` = 0, the effective bit is the base bit, and the sub-word position stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input value present; one word bit is consumed per present value |
| in_data | input | DATA_W | Input value |
| compose_en | input | 1 | 1 = base word composed with sub-word, 0 = base word alone |
| cfg_we | input | 1 | Load strobe for a word |
| cfg_sel | input | 1 | Word to load: 0 base, 1 sub |
| cfg_pre_len | input | 5 | Prefix length, 0 to 16 |
| cfg_pre_bits | input | 16 | Prefix bits, bit i = position i |
| cfg_per_len | input | 5 | Period length, 1 to 16 |
| cfg_per_bits | input | 16 | Period bits, bit i = i-th period position |
| out_valid | output | 1 | Output value present |
| out_data | output | DATA_W | Forwarded value |
| act_bit | output | 1 | Activation bit of the derived clock for this cycle |

## Verification
The activation bit is combinational, so it is due in the same cycle the inputs are driven. The bench samples it 1 ns after driving. `out_valid` and `out_data` pass through one register and are due after the next rising edge. The bench reads them 2 ns after that edge, well before the inputs for the next step change. A word load or a reset takes effect at the edge where it is sampled, and the bench model restarts its bit counts at that same edge.

// File: rtl/upw_pkg.sv
package upw_pkg;

  // Largest prefix and largest period supported, in bits.
  localparam int unsigned UPW_SEG = 16;
  localparam int unsigned PLEN_W  = $clog2(UPW_SEG + 1);
  localparam int unsigned POS_W   = $clog2(2 * UPW_SEG);
  localparam int unsigned IDX_W   = $clog2(UPW_SEG);

  typedef logic [POS_W-1:0] upw_pos_t;

  typedef struct packed {
    logic [PLEN_W-1:0]  pre_len;
    logic [UPW_SEG-1:0] pre_bits;
    logic [PLEN_W-1:0]  per_len;
    logic [UPW_SEG-1:0] per_bits;
  } upw_word_t;

  // Clamp the lengths into the supported range; an empty period becomes one bit long.
  function automatic upw_word_t upw_legalize(upw_word_t w);
    upw_word_t r;
    r = w;
    if (w.pre_len > PLEN_W'(UPW_SEG)) r.pre_len = PLEN_W'(UPW_SEG);
    if (w.per_len == '0) r.per_len = PLEN_W'(1);
    else if (w.per_len > PLEN_W'(UPW_SEG)) r.per_len = PLEN_W'(UPW_SEG);
    return r;
  endfunction

  // Index of the final bit of the periodic part.
  function automatic upw_pos_t upw_end(upw_word_t w);
    return POS_W'(w.pre_len) + POS_W'(w.per_len) - POS_W'(1);
  endfunction

  // Bit of the word at position p.
  function automatic logic upw_bit(upw_word_t w, upw_pos_t p);
    upw_pos_t off;
    if (p < POS_W'(w.pre_len)) return w.pre_bits[p[IDX_W-1:0]];
    off = p - POS_W'(w.pre_len);
    return w.per_bits[off[IDX_W-1:0]];
  endfunction

  // Position that follows p; after the final bit, go back to the first period bit.
  function automatic upw_pos_t upw_next(upw_word_t w, upw_pos_t p);
    if (p == upw_end(w)) return POS_W'(w.pre_len);
    return p + POS_W'(1);
  endfunction

  // Nesting rule: a base 0 gives 0; a base 1 passes the sub-word bit through.
  function automatic logic upw_compose(logic base_b, logic sub_b);
    return base_b & sub_b;
  endfunction

endpackage

// File: rtl/upw_word_gen.sv
module upw_word_gen
  import upw_pkg::*;
#(
  parameter int unsigned          PRE_LEN  = 0,
  parameter logic [UPW_SEG-1:0]   PRE_BITS = '0,
  parameter int unsigned          PER_LEN  = 1,
  parameter logic [UPW_SEG-1:0]   PER_BITS = '1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load_i,
  input  upw_word_t load_word_i,
  input  logic      step_i,
  output logic      bit_o,
  output upw_pos_t  pos_o
);

  localparam upw_word_t DEF_WORD = '{
    pre_len:  PLEN_W'(PRE_LEN),
    pre_bits: PRE_BITS,
    per_len:  PLEN_W'(PER_LEN),
    per_bits: PER_BITS
  };

  upw_word_t cfg_q;
  upw_pos_t  pos_q;
  upw_pos_t  end_pos;
  logic      at_end;

  assign end_pos = upw_end(cfg_q);
  assign at_end  = (pos_q == end_pos);

  // A load wins over a step in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= upw_legalize(DEF_WORD);
      pos_q <= '0;
    end else if (load_i) begin
      cfg_q <= upw_legalize(load_word_i);
      pos_q <= '0;
    end else if (step_i) begin
      pos_q <= upw_next(cfg_q, pos_q);
    end
  end

  assign bit_o = upw_bit(cfg_q, pos_q);
  assign pos_o = pos_q;

  // R2: the position never runs past the final bit of the period.
  a_r2_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    pos_q <= end_pos);

  // R2: a step on the final bit goes back to the start of the period.
  a_r2_wrap_to_period: assert property (@(posedge clk) disable iff (rst)
    step_i && !load_i && at_end |=> pos_q == POS_W'(cfg_q.pre_len));

  // R5: without a step or a load, the position holds.
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step_i && !load_i |=> $stable(pos_q));

  // R8: a load restarts the word at the first bit.
  a_r8_load_restarts: assert property (@(posedge clk) disable iff (rst)
    load_i |=> pos_q == '0);

  // R8: a loaded word always has a period of 1 to 16 bits.
  a_r8_period_legal: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cfg_q.per_len != '0) && (cfg_q.per_len <= PLEN_W'(UPW_SEG)));

endmodule

// File: rtl/upw_sample_stage.sv
module upw_sample_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= take_i;
      if (take_i) data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R3: a taken value appears one clock later.
  a_r3_pass_next_cycle: assert property (@(posedge clk) disable iff (rst)
    take_i |=> valid_o && (data_o == $past(data_i)));

  // R4: a cycle without a take gives no output value.
  a_r4_drop_next_cycle: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> !valid_o);

  // R4: a dropped value leaves the held data untouched.
  a_r4_data_held: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> $stable(data_o));

endmodule

// File: rtl/upw_sampler.sv
module upw_sampler
  import upw_pkg::*;
#(
  parameter int unsigned        DATA_W        = 8,
  parameter int unsigned        BASE_PRE_LEN  = 0,
  parameter logic [UPW_SEG-1:0] BASE_PRE_BITS = '0,
  parameter int unsigned        BASE_PER_LEN  = 2,
  parameter logic [UPW_SEG-1:0] BASE_PER_BITS = 16'h0001,
  parameter int unsigned        SUB_PRE_LEN   = 0,
  parameter logic [UPW_SEG-1:0] SUB_PRE_BITS  = '0,
  parameter int unsigned        SUB_PER_LEN   = 1,
  parameter logic [UPW_SEG-1:0] SUB_PER_BITS  = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              compose_en,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [PLEN_W-1:0] cfg_pre_len,
  input  logic [UPW_SEG-1:0] cfg_pre_bits,
  input  logic [PLEN_W-1:0] cfg_per_len,
  input  logic [UPW_SEG-1:0] cfg_per_bits,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              act_bit
);

  upw_word_t load_word;
  logic      load_base, load_sub;
  logic      base_step, sub_step;
  logic      base_bit, sub_bit;
  upw_pos_t  base_pos, sub_pos;
  logic      eff_bit;

  assign load_word = '{
    pre_len:  cfg_pre_len,
    pre_bits: cfg_pre_bits,
    per_len:  cfg_per_len,
    per_bits: cfg_per_bits
  };
  assign load_base = cfg_we && !cfg_sel;
  assign load_sub  = cfg_we &&  cfg_sel;

  // The base word moves on each present input; the sub-word moves only on present inputs where the base bit is 1.
  assign base_step = in_valid;
  assign sub_step  = in_valid && compose_en && base_bit;

  upw_word_gen #(
    .PRE_LEN (BASE_PRE_LEN),
    .PRE_BITS(BASE_PRE_BITS),
    .PER_LEN (BASE_PER_LEN),
    .PER_BITS(BASE_PER_BITS)
  ) base_word_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_base),
    .load_word_i(load_word),
    .step_i     (base_step),
    .bit_o      (base_bit),
    .pos_o      (base_pos)
  );

  upw_word_gen #(
    .PRE_LEN (SUB_PRE_LEN),
    .PRE_BITS(SUB_PRE_BITS),
    .PER_LEN (SUB_PER_LEN),
    .PER_BITS(SUB_PER_BITS)
  ) sub_word_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_sub),
    .load_word_i(load_word),
    .step_i     (sub_step),
    .bit_o      (sub_bit),
    .pos_o      (sub_pos)
  );

  assign eff_bit = compose_en ? upw_compose(base_bit, sub_bit) : base_bit;
  assign act_bit = in_valid && eff_bit;

  upw_sample_stage #(
    .DATA_W(DATA_W)
  ) stage_i (
    .clk    (clk),
    .rst    (rst),
    .take_i (act_bit),
    .data_i (in_data),
    .valid_o(out_valid),
    .data_o (out_data)
  );

  // R6: no activation without a base bit of 1.
  a_r6_act_needs_base: assert property (@(posedge clk) disable iff (rst)
    act_bit |-> base_bit);

  // R6: when the base bit is 0 or no value is present, the sub-word does not move.
  a_r6_sub_waits_on_base: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !base_bit) && !cfg_we |=> $stable(sub_pos));

  // R9: the sub-word stays frozen outside composed mode.
  a_r9_sub_frozen_plain: assert property (@(posedge clk) disable iff (rst)
    !compose_en && !cfg_we |=> $stable(sub_pos));

  // R5: the base word holds while no input is present.
  a_r5_base_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid && !cfg_we |=> $stable(base_pos));

  // R7: the activation bit never rises without a present input.
  a_r7_act_needs_valid: assert property (@(posedge clk) disable iff (rst)
    act_bit |-> in_valid);

endmodule

// File: tb/upw_sampler_tb_top.sv
module upw_sampler_tb_top;
  import upw_pkg::*;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          compose_en;
  logic          cfg_we, cfg_sel;
  logic [PLEN_W-1:0]  cfg_pre_len, cfg_per_len;
  logic [UPW_SEG-1:0] cfg_pre_bits, cfg_per_bits;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          act_bit;

  int n_checks = 0;
  int n_fail   = 0;

  // Reference model: words kept as plain lengths, plus a count of consumed bits that never wraps.
  int          b_pl, b_ll, s_pl, s_ll;
  logic [15:0] b_pb, b_lb, s_pb, s_lb;
  int          nb, ns;

  always #4 clk = ~clk;

  upw_sampler #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .compose_en(compose_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_pre_len(cfg_pre_len), .cfg_pre_bits(cfg_pre_bits),
    .cfg_per_len(cfg_per_len), .cfg_per_bits(cfg_per_bits),
    .out_valid(out_valid), .out_data(out_data), .act_bit(act_bit)
  );

  // Stimulus table: {compose, present, data}.
  localparam logic [9:0] VEC [24] = '{
    10'h1A1, 10'h1B2, 10'h0C3, 10'h1D4, 10'h1E5, 10'h1F6,
    10'h307, 10'h318, 10'h229, 10'h33A, 10'h34B, 10'h35C,
    10'h36D, 10'h27E, 10'h38F, 10'h390, 10'h1A1, 10'h1B2,
    10'h3C3, 10'h3D4, 10'h0E5, 10'h3F6, 10'h307, 10'h318
  };

  function automatic logic mbit(int pl, logic [15:0] pb, int ll, logic [15:0] lb, int n);
    if (n < pl) return pb[n];
    return lb[(n - pl) % ll];
  endfunction

  function automatic int fix_pre(int x);
    return (x > 16) ? 16 : x;
  endfunction

  function automatic int fix_per(int x);
    if (x == 0) return 1;
    return (x > 16) ? 16 : x;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_defaults();
    b_pl = 0; b_pb = 16'h0; b_ll = 2; b_lb = 16'h0001;
    s_pl = 0; s_pb = 16'h0; s_ll = 1; s_lb = 16'h0001;
    nb = 0; ns = 0;
  endtask

  // Drive one step; check act_bit in the same cycle and the outputs after the edge.
  task automatic apply(input logic v, input logic [DW-1:0] d, input logic m, input string tag);
    logic b, s, e;
    b = mbit(b_pl, b_pb, b_ll, b_lb, nb);
    s = mbit(s_pl, s_pb, s_ll, s_lb, ns);
    e = m ? (b & s) : b;
    in_valid = v; in_data = d; compose_en = m;
    #1;
    chk(act_bit === (v & e), {tag, " R7 act_bit"}, int'(act_bit), int'(v & e));
    @(posedge clk);
    #2;
    chk(out_valid === (v & e), {tag, " R3/R4 out_valid"}, int'(out_valid), int'(v & e));
    if (v & e)
      chk(out_data === d, {tag, " R3 out_data"}, int'(out_data), int'(d));
    if (v) nb++;
    if (v & m & b) ns++;
    in_valid = 1'b0;
  endtask

  task automatic load(input logic sel, input int pl, input logic [15:0] pb,
                      input int ll, input logic [15:0] lb);
    cfg_we = 1'b1; cfg_sel = sel; in_valid = 1'b0;
    cfg_pre_len = PLEN_W'(pl); cfg_pre_bits = pb;
    cfg_per_len = PLEN_W'(ll); cfg_per_bits = lb;
    @(posedge clk);
    #2;
    cfg_we = 1'b0;
    if (!sel) begin b_pl = fix_pre(pl); b_pb = pb; b_ll = fix_per(ll); b_lb = lb; nb = 0; end
    else      begin s_pl = fix_pre(pl); s_pb = pb; s_ll = fix_per(ll); s_lb = lb; ns = 0; end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; compose_en = 1'b0;
    cfg_we = 1'b0; cfg_sel = 1'b0;
    cfg_pre_len = '0; cfg_per_len = '0; cfg_pre_bits = '0; cfg_per_bits = '0;
    model_defaults();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    // R1: nothing is present straight after reset.
    chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    // R1: the default base word (10) starts at its first bit, which is 1.
    apply(1'b1, 8'h11, 1'b0, "R1 first bit");

    // Default words: base (10), sub (1).
    for (int i = 0; i < 24; i++)
      apply(VEC[i][8], VEC[i][7:0], VEC[i][9], "R6/R9 table default");

    // R2: base 0001(1001), sub 1(0); vectors bit i = position i.
    load(1'b0, 4, 16'h0008, 4, 16'h0009);
    load(1'b1, 1, 16'h0001, 1, 16'h0000);
    for (int i = 0; i < 24; i++)
      apply(VEC[i][8], VEC[i][7:0], VEC[i][9], "R2/R6 table loaded");

    // R5: idle cycles leave the base position where it was.
    apply(1'b0, 8'h55, 1'b0, "R5 idle");
    apply(1'b0, 8'h56, 1'b1, "R5 idle");
    for (int i = 0; i < 6; i++) apply(1'b1, 8'(8'h60 + i), 1'b0, "R5 resume");

    // R8: an empty period becomes one bit, an oversized prefix is cut to 16 bits.
    load(1'b0, 0, 16'h0000, 0, 16'h0001);
    for (int i = 0; i < 4; i++) apply(1'b1, 8'(8'h70 + i), 1'b0, "R8 empty period");
    load(1'b0, 20, 16'hA5F0, 3, 16'h0006);
    for (int i = 0; i < 22; i++) apply(1'b1, 8'(8'h80 + i), 1'b0, "R8 long prefix");

    // R9: a sub-word with a prefix stays put in plain mode, then resumes in composed mode.
    load(1'b1, 2, 16'h0002, 2, 16'h0001);
    load(1'b0, 0, 16'h0000, 1, 16'h0001);
    for (int i = 0; i < 3; i++) apply(1'b1, 8'(8'h90 + i), 1'b0, "R9 plain");
    for (int i = 0; i < 6; i++) apply(1'b1, 8'(8'hA0 + i), 1'b1, "R9 composed");

    // R1: a reset in the middle of a stream restores the defaults.
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    model_defaults();
    chk(out_valid === 1'b0, "R1 out_valid mid reset", int'(out_valid), 0);
    for (int i = 0; i < 4; i++) apply(1'b1, 8'(8'hB0 + i), 1'b1, "R1 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule